// File: doc/BRIEF.md
# Prescaled Interval Timer with Watchdog

This block is an 8-bit interval timer that runs from a power-of-two division of the system clock. A free-running prescaler provides the taps. A 3-bit select field in a small mode register picks one tap. Each time the chosen tap completes a period, the 8-bit counter advances by one. When the counter wraps from FFh to 00h, the block sets an interrupt request flag and keeps counting. Software clears the flag through an acknowledge input.

The same counter wrap does two more jobs. First, it ends the oscillator-stabilization wait. That wait is armed at reset, and again by a wake-up request that arrives while the clock is stopped. The block holds a busy output high during the wait and gives a one-cycle done pulse when the wait ends. Second, it clocks a 3-bit watchdog counter. If software does not clear that counter in time, the watchdog wraps and the block emits a one-cycle system-reset request. Writing one reserved key value to the watchdog control register stops the watchdog. Any other value starts it again.

Software reaches the block through a single-cycle write port. The port has a 2-bit address and an 8-bit data field.

Top module: `interval_wdt`

## Requirements
- R1: After reset, the outputs are: `bt_cnt`=0, `irq`=0, `stab_busy`=1, `stab_done`=0, `wdt_rst`=0. The tap select is 011, and the watchdog is enabled with its count at zero.
- R2: The tap select uses these codes: 011 selects 2^DIV_B cycles per tick, 101 selects 2^DIV_C, and 111 selects 2^DIV_D. The codes 000 and all other values select 2^DIV_A. After a restart, `bt_cnt` equals floor(k / 2^d) mod 256 after k clock edges, where d is the exponent of the selected tap.
- R3: The counter wraps on the 256th tick after a restart. At that edge `bt_cnt` returns to 0 and `irq` becomes 1. Counting then continues without a pause.
- R4: A write to address 0 loads data bits 2..0 as the tap select. If data bit 3 is 1, the write also clears the counter and the prescaler. If data bit 3 is 0, the counter is not disturbed.
- R5: `irq_ack` clears `irq` on the next edge. If a wrap happens on the same edge, the wrap wins and `irq` stays 1.
- R6: After reset, `stab_busy` stays high until the first wrap, which comes 256·2^DIV_B cycles later. At that edge `stab_busy` falls and `stab_done` is high for exactly one cycle.
- R7: `wake_req` while `stop_mode` is 1 has these effects: it clears the counter and prescaler, raises `stab_busy` until the next wrap, and then gives a one-cycle `stab_done` pulse. `wake_req` while `stop_mode` is 0 has no effect.
- R8: While the watchdog is enabled, each counter wrap advances the 3-bit watchdog count. The eighth wrap after the count was last zero drives `wdt_rst` high for exactly one cycle.
- R9: A write to address 2 with data bit 0 set clears the watchdog count. This takes priority over a wrap on the same edge.
- R10: A write to address 1 with data 5Ah disables the watchdog, and its count holds its value. A write to address 1 with any other value enables it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 mode, 1 watchdog control, 2 watchdog clear |
| wr_data | input | 8 | Write data |
| irq_ack | input | 1 | Clears the interrupt request flag |
| stop_mode | input | 1 | High while the system clock is stopped |
| wake_req | input | 1 | Wake-up request |
| bt_cnt | output | 8 | Current value of the interval counter |
| irq | output | 1 | Interrupt request flag |
| stab_busy | output | 1 | Oscillator stabilization wait in progress |
| stab_done | output | 1 | One-cycle pulse when the stabilization wait ends |
| wdt_rst | output | 1 | One-cycle system-reset request from the watchdog |

## Verification
Every result of this block is registered. A write, acknowledge or wake presented before edge E takes effect at edge E. After a restart at edge E, the counter shows its j-th increment at edge E + j·2^d, and the wrap with its `irq`, `stab_done` and `wdt_rst` effects lands at edge E + 256·2^d. The bench counts clock edges from each stimulus and compares every output against these closed-form values on the falling edge in every cycle. As a result, an output that comes one cycle early or late fails at the exact cycle where it goes wrong. The watchdog checks place clears and enable changes at known edges. Each check then predicts which wrap count produces the single reset cycle.

// File: rtl/interval_wdt.sv
module interval_wdt #(
  parameter int          CNT_W  = 8,
  parameter int          WD_W   = 3,
  parameter int          DIV_A  = 12,
  parameter int          DIV_B  = 9,
  parameter int          DIV_C  = 7,
  parameter int          DIV_D  = 5,
  parameter logic [7:0]  WD_KEY = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             irq_ack,
  input  logic             stop_mode,
  input  logic             wake_req,
  output logic [CNT_W-1:0] bt_cnt,
  output logic             irq,
  output logic             stab_busy,
  output logic             stab_done,
  output logic             wdt_rst
);
  localparam int PRE_W = DIV_A;
  localparam logic [PRE_W-1:0] ONES   = {PRE_W{1'b1}};
  localparam logic [PRE_W-1:0] MASK_A = ONES;
  localparam logic [PRE_W-1:0] MASK_B = ONES >> (PRE_W - DIV_B);
  localparam logic [PRE_W-1:0] MASK_C = ONES >> (PRE_W - DIV_C);
  localparam logic [PRE_W-1:0] MASK_D = ONES >> (PRE_W - DIV_D);
  localparam logic [2:0] SEL_RST = 3'b011;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;
  logic [2:0]       sel;
  logic [WD_W-1:0]  wd_cnt;
  logic             wd_en;

  wire wr_mode = wr_en && (wr_addr == 2'd0);
  wire wr_wdm  = wr_en && (wr_addr == 2'd1);
  wire wd_clr  = wr_en && (wr_addr == 2'd2) && wr_data[0];
  wire wake_go = wake_req && stop_mode;
  wire zap     = (wr_mode && wr_data[3]) || wake_go;

  always_comb begin
    case (sel)
      3'b011:  mask = MASK_B;
      3'b101:  mask = MASK_C;
      3'b111:  mask = MASK_D;
      default: mask = MASK_A;
    endcase
  end

  wire tick = ((pre & mask) == mask) && !zap;
  wire wrap = tick && (&bt_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre    <= '0;
      bt_cnt <= '0;
      sel    <= SEL_RST;
    end else begin
      pre    <= zap ? '0 : pre + 1'b1;
      if (zap)       bt_cnt <= '0;
      else if (tick) bt_cnt <= bt_cnt + 1'b1;
      if (wr_mode)   sel <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      stab_busy <= 1'b1;
      stab_done <= 1'b0;
    end else begin
      if (wrap)         irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
      if (wake_go)      stab_busy <= 1'b1;
      else if (wrap)    stab_busy <= 1'b0;
      stab_done <= wrap && stab_busy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_en   <= 1'b1;
      wd_cnt  <= '0;
      wdt_rst <= 1'b0;
    end else begin
      if (wr_wdm)              wd_en  <= (wr_data != WD_KEY);
      if (wd_clr)              wd_cnt <= '0;
      else if (wrap && wd_en)  wd_cnt <= wd_cnt + 1'b1;
      wdt_rst <= wrap && wd_en && !wd_clr && (&wd_cnt);
    end
  end
endmodule

// File: rtl/interval_wdt_chk.sv
module interval_wdt_chk #(parameter int CNT_W = 8) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] bt_cnt,
  input logic             irq,
  input logic             stab_busy,
  input logic             stab_done,
  input logic             wdt_rst
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bt_cnt != $past(bt_cnt)) |-> (bt_cnt == CNT_W'($past(bt_cnt) + 1'b1) || bt_cnt == '0)); // R2
  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (bt_cnt == '0)); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stab_done |=> !stab_done); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stab_done |-> (!stab_busy && $past(stab_busy))); // R7
  AST_WDT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst); // R8
  AST_WDT_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (bt_cnt == '0 && irq)); // R8
endmodule

bind interval_wdt interval_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bt_cnt(bt_cnt), .irq(irq),
  .stab_busy(stab_busy), .stab_done(stab_done), .wdt_rst(wdt_rst)
);

// File: tb/test_interval_wdt.sv
module test_interval_wdt;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, irq_ack = 0, stop_mode = 0, wake_req = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] bt_cnt;
  logic irq, stab_busy, stab_done, wdt_rst;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  interval_wdt #(.DIV_A(4), .DIV_B(3), .DIV_C(2), .DIV_D(1)) i_interval_wdt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_ack(irq_ack), .stop_mode(stop_mode), .wake_req(wake_req), .bt_cnt(bt_cnt),
    .irq(irq), .stab_busy(stab_busy), .stab_done(stab_done), .wdt_rst(wdt_rst));

  function automatic int dexp(input int code);
    return (code == 3) ? 3 : (code == 5) ? 2 : (code == 7) ? 1 : 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic ack);
    wr_en = 1; wr_addr = a; wr_data = d; irq_ack = ack;
    @(negedge clk);
    wr_en = 0; irq_ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout act=1 exp=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p, n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(bt_cnt == 0 && !irq && stab_busy && !stab_done && !wdt_rst, "R1 reset state",
        {bt_cnt, irq, stab_busy, stab_done, wdt_rst}, 8'h0 << 4 | 4'b0100);

    p = 256 * 8;
    for (int k = 1; k <= 8 * p + 1; k++) begin
      @(negedge clk);
      chk(bt_cnt == ((k >> 3) % 256), "R2 default tap count", bt_cnt, (k >> 3) % 256);
      chk(stab_busy == (k < p), "R6 busy after reset", stab_busy, k < p);
      chk(stab_done == (k == p), "R6 done pulse", stab_done, k == p);
      chk(irq == (k >= p), "R3 irq after reset", irq, k >= p);
      chk(wdt_rst == (k == 8 * p), "R8 wdt after 8 wraps", wdt_rst, k == 8 * p);
    end

    wr(2'd1, 8'h5A, 1'b0);
    for (int code = 0; code < 8; code++) begin
      int d;
      d = dexp(code);
      n = 256 << d;
      wr(2'd0, 8'h08 | code[7:0], 1'b1);
      for (int k = 1; k <= n + 2; k++) begin
        if (k == n) irq_ack = 1;
        if (code == 7 && k == 100) begin wr_en = 1; wr_addr = 0; wr_data = 8'h07; end
        @(negedge clk);
        irq_ack = 0;
        wr_en = 0;
        chk(bt_cnt == ((k >> d) % 256), $sformatf("R2 code %0d count", code), bt_cnt, (k >> d) % 256);
        if (code == 7 && k == 100)
          chk(bt_cnt == 50, "R4 bit3 clear keeps count", bt_cnt, 50);
        chk(irq == (k >= n), $sformatf("R3 code %0d irq", code), irq, k >= n);
        if (k == n) chk(irq == 1, "R5 wrap beats ack", irq, 1);
        chk(wdt_rst == 0, "R10 disabled watchdog", wdt_rst, 0);
      end
      wr(2'd3, 8'h00, 1'b1);
      chk(irq == 0, "R5 ack clears irq", irq, 0);
    end

    n = 512;
    wr(2'd0, 8'h0F, 1'b0);
    for (int k = 1; k <= 20; k++) @(negedge clk);
    wake_req = 1; @(negedge clk); wake_req = 0;
    chk(!stab_busy && bt_cnt == 10, "R7 wake ignored when running", bt_cnt, 10);
    stop_mode = 1;
    wake_req = 1; @(negedge clk); wake_req = 0;
    chk(stab_busy && bt_cnt == 0, "R7 wake clears and arms", {stab_busy, bt_cnt}, 9'h100);
    for (int k = 1; k <= n + 1; k++) begin
      @(negedge clk);
      chk(bt_cnt == ((k >> 1) % 256), "R7 count after wake", bt_cnt, (k >> 1) % 256);
      chk(stab_busy == (k < n), "R7 busy until wrap", stab_busy, k < n);
      chk(stab_done == (k == n), "R7 done pulse", stab_done, k == n);
    end
    stop_mode = 0;

    wr(2'd1, 8'h00, 1'b0);
    wr(2'd2, 8'h01, 1'b0);
    wr(2'd0, 8'h0F, 1'b0);
    for (int k = 1; k <= 18 * n + 1; k++) begin
      if (k == 4 * n + 5)  begin wr_en = 1; wr_addr = 1; wr_data = 8'h5A; end
      if (k == 14 * n + 5) begin wr_en = 1; wr_addr = 1; wr_data = 8'hA5; end
      @(negedge clk);
      wr_en = 0;
      chk(wdt_rst == (k == 18 * n), "R10 disable holds count", wdt_rst, k == 18 * n);
    end

    wr(2'd2, 8'h01, 1'b0);
    wr(2'd0, 8'h0F, 1'b0);
    for (int k = 1; k <= 15 * n + 1; k++) begin
      if (k == 7 * n + 10) begin wr_en = 1; wr_addr = 2; wr_data = 8'h01; end
      @(negedge clk);
      wr_en = 0;
      chk(wdt_rst == (k == 15 * n), "R9 clear restarts watchdog", wdt_rst, k == 15 * n);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule